// File: doc/BRIEF.md
# Reciprocal-multiply modulo unit

This unit computes the remainder and the quotient of a 15-bit unsigned dividend taken against one of twelve fixed divisors, with no divider circuit. A 4-bit select code names the divisor. A constant table gives the rounded 16-fraction-bit reciprocal of that divisor. The dividend is multiplied by the reciprocal, rounded at the half-LSB and shifted right by 16 bits, which gives a quotient estimate. That estimate is multiplied back by the divisor and subtracted from the dividend, which gives a raw remainder.

The estimate can be one too high, from rounding, or one too low, from the limited precision of the reciprocal. A final stage therefore moves the raw remainder back into the range 0 to N-1 by one step of N and adjusts the quotient to match.

The work is split across three register stages. The unit accepts one operand per cycle and returns one result per cycle, with a fixed latency. A select code with no divisor behind it produces a flagged result whose value fields are zero.

Top module: `recip_mod_unit`

## Requirements
- R1: While rst_n is low, out_vld, out_err, out_rem and out_quot are all 0. This reset acts asynchronously.
- R2: The legal codes of in_sel map to divisors in ascending order: 0→48, 1→64, 2→212, 3→220, 4→228, 5→424, 6→432, 7→440, 8→752, 9→848, 10→856, 11→864.
- R3: For a legal in_sel, out_rem equals in_x mod N for every 15-bit in_x. This includes 0, 32767, exact multiples of N and the value one below a multiple.
- R4: For a legal in_sel, out_quot equals floor(in_x / N).
- R5: out_vld is high exactly three clock cycles after a cycle with in_vld high, and low otherwise. Back-to-back inputs give back-to-back results.
- R6: An in_sel of 12 to 15 gives a result with out_err = 1, out_rem = 0 and out_quot = 0, at the same latency as a legal result. A legal in_sel gives out_err = 0.
- R7: While out_vld is low, out_rem, out_quot and out_err keep the values of the last result. After a reset they keep 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | An operand is presented this cycle |
| in_x | input | 15 | Unsigned dividend |
| in_sel | input | 4 | Divisor select code |
| out_vld | output | 1 | A result is presented this cycle |
| out_rem | output | 10 | Remainder |
| out_quot | output | 15 | Quotient |
| out_err | output | 1 | The select code had no divisor |

## Verification
The bench streams a wide spread of dividends against every divisor, including 0, 32767, exact multiples and their predecessors. At those points a design without the correction stage, or with a wrong table entry, would return a remainder of N or a negative remainder wrapped to a large value, together with a quotient that is off by one. Illegal select codes are mixed into a stream so that a missing error path shows up as a stale or nonzero remainder, or as a missing out_err. A reset applied while the pipeline is full must discard the results in flight; a design whose valid bits ignore the asynchronous reset would emit them afterwards. The idle cycles between results are checked to confirm that the outputs hold their last values.

// File: rtl/recip_mod_pkg.sv
package recip_mod_pkg;
  localparam int XW   = 15;
  localparam int RFW  = 16;
  localparam int NW   = 10;
  localparam int SELW = 4;
  localparam int NDIV = 12;

  function automatic int div_of(input int idx);
    case (idx)
      0:       return 48;
      1:       return 64;
      2:       return 212;
      3:       return 220;
      4:       return 228;
      5:       return 424;
      6:       return 432;
      7:       return 440;
      8:       return 752;
      9:       return 848;
      10:      return 856;
      11:      return 864;
      default: return 0;
    endcase
  endfunction

  // rounded reciprocal with fbits fraction bits
  function automatic int recip_calc(input int n, input int fbits);
    if (n == 0) return 0;
    return ((1 << fbits) + n / 2) / n;
  endfunction
endpackage

// File: rtl/recip_mod_lut.sv
module recip_mod_lut
  import recip_mod_pkg::*;
#(
  parameter int SELW_P = SELW,
  parameter int NW_P   = NW,
  parameter int RFW_P  = RFW,
  parameter int NDIV_P = NDIV
) (
  input  logic [SELW_P-1:0] sel,
  output logic [NW_P-1:0]   n,
  output logic [RFW_P-1:0]  recip,
  output logic              bad
);
  localparam int NENT = 1 << SELW_P;

  logic [NW_P-1:0]  n_tab [NENT];
  logic [RFW_P-1:0] r_tab [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    localparam int NVI = (g < NDIV_P) ? div_of(g) : 0;
    assign n_tab[g] = NW_P'(NVI);
    assign r_tab[g] = RFW_P'(recip_calc(NVI, RFW_P));
  end

  assign n     = n_tab[sel];
  assign recip = r_tab[sel];
  assign bad   = (32'(sel) >= NDIV_P);
endmodule

// File: rtl/recip_mod_est.sv
module recip_mod_est
  import recip_mod_pkg::*;
#(
  parameter int XW_P   = XW,
  parameter int SELW_P = SELW,
  parameter int NW_P   = NW,
  parameter int RFW_P  = RFW,
  parameter int NDIV_P = NDIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [XW_P-1:0]   in_x,
  input  logic [SELW_P-1:0] in_sel,
  output logic              s1_vld,
  output logic [XW_P-1:0]   s1_x,
  output logic [NW_P-1:0]   s1_n,
  output logic [XW_P-1:0]   s1_q,
  output logic              s1_bad
);
  localparam int PW = XW_P + RFW_P;

  logic [NW_P-1:0]  lut_n;
  logic [RFW_P-1:0] lut_r;
  logic             lut_bad;
  logic [XW_P-1:0]  q_d;

  recip_mod_lut #(
    .SELW_P(SELW_P), .NW_P(NW_P), .RFW_P(RFW_P), .NDIV_P(NDIV_P)
  ) u_lut (
    .sel(in_sel), .n(lut_n), .recip(lut_r), .bad(lut_bad)
  );

  // quotient estimate: multiply, add half LSB, drop fraction
  always_comb begin
    q_d = XW_P'((PW'(in_x) * PW'(lut_r) + (PW'(1) << (RFW_P - 1))) >> RFW_P);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_x   <= in_x;
      s1_n   <= lut_n;
      s1_q   <= q_d;
      s1_bad <= lut_bad;
    end
  end
endmodule

// File: rtl/recip_mod_sub.sv
module recip_mod_sub
  import recip_mod_pkg::*;
#(
  parameter int XW_P = XW,
  parameter int NW_P = NW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_vld,
  input  logic [XW_P-1:0]      s1_x,
  input  logic [NW_P-1:0]      s1_n,
  input  logic [XW_P-1:0]      s1_q,
  input  logic                 s1_bad,
  output logic                 s2_vld,
  output logic [XW_P+NW_P:0]   s2_raw,
  output logic [XW_P-1:0]      s2_q,
  output logic [NW_P-1:0]      s2_n,
  output logic                 s2_bad
);
  localparam int MW = XW_P + NW_P;
  localparam int DW = MW + 1;

  logic [DW-1:0] raw_d;

  // two's-complement raw remainder: dividend minus estimate times divisor
  always_comb begin
    raw_d = {1'b0, MW'(s1_x)} - {1'b0, MW'(s1_q) * MW'(s1_n)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_raw <= raw_d;
      s2_q   <= s1_q;
      s2_n   <= s1_n;
      s2_bad <= s1_bad;
    end
  end
endmodule

// File: rtl/recip_mod_fix.sv
module recip_mod_fix
  import recip_mod_pkg::*;
#(
  parameter int XW_P = XW,
  parameter int NW_P = NW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s2_vld,
  input  logic [XW_P+NW_P:0]   s2_raw,
  input  logic [XW_P-1:0]      s2_q,
  input  logic [NW_P-1:0]      s2_n,
  input  logic                 s2_bad,
  output logic                 out_vld,
  output logic [NW_P-1:0]      out_rem,
  output logic [XW_P-1:0]      out_quot,
  output logic                 out_err
);
  localparam int MW = XW_P + NW_P;
  localparam int DW = MW + 1;

  logic            neg;
  logic            over;
  logic [NW_P-1:0] rem_d;
  logic [XW_P-1:0] quot_d;
  logic            err_d;

  always_comb begin
    neg  = s2_raw[DW-1];
    over = !neg && (s2_raw[MW-1:0] >= MW'(s2_n));
    if (s2_bad) begin
      rem_d  = '0;
      quot_d = '0;
      err_d  = 1'b1;
    end else if (neg) begin
      rem_d  = NW_P'(s2_raw + DW'(s2_n));
      quot_d = s2_q - XW_P'(1);
      err_d  = 1'b0;
    end else if (over) begin
      rem_d  = NW_P'(s2_raw - DW'(s2_n));
      quot_d = s2_q + XW_P'(1);
      err_d  = 1'b0;
    end else begin
      rem_d  = NW_P'(s2_raw);
      quot_d = s2_q;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_rem  <= '0;
      out_quot <= '0;
      out_err  <= 1'b0;
    end else begin
      out_vld <= s2_vld;
      if (s2_vld) begin
        out_rem  <= rem_d;
        out_quot <= quot_d;
        out_err  <= err_d;
      end
    end
  end
endmodule

// File: rtl/recip_mod_unit.sv
module recip_mod_unit
  import recip_mod_pkg::*;
#(
  parameter int XW_P   = XW,
  parameter int SELW_P = SELW,
  parameter int NW_P   = NW,
  parameter int RFW_P  = RFW,
  parameter int NDIV_P = NDIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [XW_P-1:0]   in_x,
  input  logic [SELW_P-1:0] in_sel,
  output logic              out_vld,
  output logic [NW_P-1:0]   out_rem,
  output logic [XW_P-1:0]   out_quot,
  output logic              out_err
);
  logic               s1_vld;
  logic [XW_P-1:0]    s1_x;
  logic [NW_P-1:0]    s1_n;
  logic [XW_P-1:0]    s1_q;
  logic               s1_bad;
  logic               s2_vld;
  logic [XW_P+NW_P:0] s2_raw;
  logic [XW_P-1:0]    s2_q;
  logic [NW_P-1:0]    s2_n;
  logic               s2_bad;

  recip_mod_est #(
    .XW_P(XW_P), .SELW_P(SELW_P), .NW_P(NW_P), .RFW_P(RFW_P), .NDIV_P(NDIV_P)
  ) u_est (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .in_sel(in_sel),
    .s1_vld(s1_vld), .s1_x(s1_x), .s1_n(s1_n), .s1_q(s1_q), .s1_bad(s1_bad)
  );

  recip_mod_sub #(.XW_P(XW_P), .NW_P(NW_P)) u_sub (
    .clk(clk), .rst_n(rst_n),
    .s1_vld(s1_vld), .s1_x(s1_x), .s1_n(s1_n), .s1_q(s1_q), .s1_bad(s1_bad),
    .s2_vld(s2_vld), .s2_raw(s2_raw), .s2_q(s2_q), .s2_n(s2_n), .s2_bad(s2_bad)
  );

  recip_mod_fix #(.XW_P(XW_P), .NW_P(NW_P)) u_fix (
    .clk(clk), .rst_n(rst_n),
    .s2_vld(s2_vld), .s2_raw(s2_raw), .s2_q(s2_q), .s2_n(s2_n), .s2_bad(s2_bad),
    .out_vld(out_vld), .out_rem(out_rem), .out_quot(out_quot), .out_err(out_err)
  );
endmodule

// File: rtl/recip_mod_chk.sv
module recip_mod_chk
  import recip_mod_pkg::*;
#(
  parameter int XW_P   = XW,
  parameter int SELW_P = SELW,
  parameter int NW_P   = NW,
  parameter int NDIV_P = NDIV
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [XW_P-1:0]   in_x,
  input logic [SELW_P-1:0] in_sel,
  input logic              out_vld,
  input logic [NW_P-1:0]   out_rem,
  input logic [XW_P-1:0]   out_quot,
  input logic              out_err
);
  localparam int MW = XW_P + NW_P;

  logic [2:0]        sh_v;
  logic [XW_P-1:0]   sh_x [3];
  logic [SELW_P-1:0] sh_s [3];
  logic [NW_P-1:0]   sh_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v <= '0;
      for (int i = 0; i < 3; i++) begin
        sh_x[i] <= '0;
        sh_s[i] <= '0;
      end
    end else begin
      sh_v    <= {sh_v[1:0], in_vld};
      sh_x[0] <= in_x;
      sh_s[0] <= in_sel;
      for (int i = 1; i < 3; i++) begin
        sh_x[i] <= sh_x[i-1];
        sh_s[i] <= sh_s[i-1];
      end
    end
  end

  assign sh_n = NW_P'(div_of(int'(sh_s[2])));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && !out_err && out_rem == '0 && out_quot == '0));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == sh_v[2]);

  assert_rem_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_err) |-> (out_rem < sh_n));

  assert_recon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_err) |->
      (MW'(out_quot) * MW'(sh_n) + MW'(out_rem) == MW'(sh_x[2])));

  assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_err == (32'(sh_s[2]) >= NDIV_P)));

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_err) |-> (out_rem == '0 && out_quot == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_rem) && $stable(out_quot) && $stable(out_err)));
endmodule

bind recip_mod_unit recip_mod_chk #(
  .XW_P(XW_P), .SELW_P(SELW_P), .NW_P(NW_P), .NDIV_P(NDIV_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .in_sel(in_sel),
  .out_vld(out_vld), .out_rem(out_rem), .out_quot(out_quot), .out_err(out_err)
);

// File: tb/recip_mod_unit_bench.sv
`timescale 1ns/1ps
module recip_mod_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [14:0] in_x;
  logic [3:0]  in_sel;
  logic        out_vld;
  logic [9:0]  out_rem;
  logic [14:0] out_quot;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // pipeline of expectations: index 0 newest
  logic        hv [3];
  logic [14:0] hq [3];
  logic [9:0]  hr [3];
  logic        he [3];
  logic [14:0] last_q;
  logic [9:0]  last_r;
  logic        last_e;

  // {x, sel, quotient, remainder}
  localparam logic [43:0] VEC [10] = '{
    {15'd32767, 4'd0,  15'd682, 10'd31},
    {15'd32767, 4'd1,  15'd511, 10'd63},
    {15'd32767, 4'd2,  15'd154, 10'd119},
    {15'd32767, 4'd11, 15'd37,  10'd799},
    {15'd0,     4'd5,  15'd0,   10'd0},
    {15'd32560, 4'd7,  15'd74,  10'd0},
    {15'd32559, 4'd7,  15'd73,  10'd439},
    {15'd32767, 4'd8,  15'd43,  10'd431},
    {15'd1234,  4'd12, 15'd0,   10'd0},
    {15'd32767, 4'd15, 15'd0,   10'd0}
  };

  recip_mod_unit u_recip_mod_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .in_sel(in_sel),
    .out_vld(out_vld), .out_rem(out_rem), .out_quot(out_quot), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int bdiv(input int s);
    case (s)
      0: return 48;   1: return 64;   2: return 212;  3: return 220;
      4: return 228;  5: return 424;  6: return 432;  7: return 440;
      8: return 752;  9: return 848;  10: return 856; 11: return 864;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      hv[i] = 1'b0; hq[i] = '0; hr[i] = '0; he[i] = 1'b0;
    end
    last_q = '0; last_r = '0; last_e = 1'b0;
  endtask

  task automatic check_out();
    chk("R5 out_vld", int'(out_vld), int'(hv[2]));
    if (hv[2]) begin
      chk(he[2] ? "R6 out_quot" : "R2 R4 out_quot", int'(out_quot), int'(hq[2]));
      chk(he[2] ? "R6 out_rem"  : "R2 R3 out_rem",  int'(out_rem),  int'(hr[2]));
      chk("R6 out_err", int'(out_err), int'(he[2]));
      last_q = hq[2]; last_r = hr[2]; last_e = he[2];
    end else begin
      chk("R7 hold quot", int'(out_quot), int'(last_q));
      chk("R7 hold rem",  int'(out_rem),  int'(last_r));
      chk("R7 hold err",  int'(out_err),  int'(last_e));
    end
  endtask

  task automatic step(input logic v, input int x, input int s,
                      input int eq, input int er, input logic ee);
    @(negedge clk);
    check_out();
    for (int i = 2; i > 0; i--) begin
      hv[i] = hv[i-1]; hq[i] = hq[i-1]; hr[i] = hr[i-1]; he[i] = he[i-1];
    end
    hv[0] = v; hq[0] = 15'(eq); hr[0] = 10'(er); he[0] = ee;
    in_vld = v; in_x = 15'(x); in_sel = 4'(s);
  endtask

  task automatic push_calc(input int x, input int s);
    int n;
    n = bdiv(s);
    if (n == 0) step(1'b1, x, s, 0, 0, 1'b1);
    else        step(1'b1, x, s, x / n, x % n, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_vld = 1'b0;
    clear_hist();
    #1;
    chk("R1 reset out_vld",  int'(out_vld),  0);
    chk("R1 reset out_err",  int'(out_err),  0);
    chk("R1 reset out_rem",  int'(out_rem),  0);
    chk("R1 reset out_quot", int'(out_quot), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_x = '0; in_sel = '0;
    clear_hist();
    repeat (2) @(negedge clk);
    chk("R1 reset out_vld",  int'(out_vld),  0);
    chk("R1 reset out_rem",  int'(out_rem),  0);
    rst_n = 1'b1;

    // table of hand-worked vectors, back to back
    for (int v = 0; v < 10; v++) begin
      step(1'b1, int'(VEC[v][43:29]), int'(VEC[v][28:25]), int'(VEC[v][24:10]),
           int'(VEC[v][9:0]), VEC[v][28:25] >= 4'd12);
    end
    repeat (5) step(1'b0, 0, 0, 0, 0, 1'b0);

    // exact multiples and their predecessors for every divisor (R3, R4)
    for (int s = 0; s < 12; s++) begin
      for (int k = 1; k * bdiv(s) <= 32767; k += 5) begin
        push_calc(k * bdiv(s), s);
        push_calc(k * bdiv(s) - 1, s);
      end
    end

    // spread sweep with illegal selects and idle gaps mixed in
    for (int s = 0; s < 12; s++) begin
      for (int i = 0; i < 12288; i++) begin
        push_calc((i * 11 + s * 97) % 32768, s);
        if (i % 1000 == 999) begin
          push_calc(i, 12 + (i / 1000) % 4);
          step(1'b0, 0, 0, 0, 0, 1'b0);
        end
      end
    end
    repeat (5) step(1'b0, 0, 0, 0, 0, 1'b0);

    // reset with the pipeline full: results in flight are dropped (R1, R5)
    for (int i = 0; i < 3; i++) push_calc(30000 + i, 9);
    do_reset();
    repeat (5) step(1'b0, 0, 0, 0, 0, 1'b0);
    push_calc(32767, 10);
    repeat (5) step(1'b0, 0, 0, 0, 0, 1'b0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule